// File: doc/BRIEF.md
# Sixteen-Bit Multiply-Accumulate Unit with Dependency Stall

This unit is the multiply-accumulate execution slice of a 32-bit integer core. An issued operation takes the low sixteen bits of each of its two 32-bit source operands and multiplies them, either as unsigned numbers or as two's-complement numbers. It then adds the product into a 40-bit running accumulator. The accumulator is split across two architectural registers. A dedicated 32-bit accumulator register holds bits [31:0]. Bits [7:0] of a separate 32-bit high register hold bits [39:32], and the upper 24 bits of that high register are left to software.

The low 32 bits of each new accumulator value are also returned on a writeback port, tagged with the destination register named at issue. An operation issues in a single cycle and its result appears two cycles later. Decode presents the source tags of the instruction that follows a multiply-accumulate, and the unit raises a stall for exactly one cycle when that instruction reads the pending destination. Consecutive multiply-accumulates chain through the accumulator with no stall. Software can write either accumulator register, and both registers are always visible on output ports.

Top module: `mac_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `hi_o`, `acc_lo_o`, `wb_valid`, `wb_data` and `stall` are all zero.
- R2: With `iss_kind` = 0 (unsigned), the product is the unsigned product of `iss_src_a[15:0]` and `iss_src_b[15:0]`, zero-extended to 40 bits. Bits [31:16] of both operands have no effect on the result.
- R3: With `iss_kind` = 1 (signed), both 16-bit fields are taken as two's-complement values, and the 32-bit product is sign-extended to 40 bits before the add.
- R4: Each operation replaces the 40-bit accumulator {`hi_o[7:0]`, `acc_lo_o`} with the old accumulator plus the extended product, wrapping modulo 2^40. No overflow indication is given.
- R5: An operation issued in cycle t raises `wb_valid` in cycle t+2. In that cycle `wb_dst` is the issue tag and `wb_data` equals the new `acc_lo_o`. Both accumulator registers show the new value in the same cycle.
- R6: A multiply-accumulate never changes `hi_o[31:8]`.
- R7: `stall` is 1 only in the cycle right after an issue, and only when `dep_valid` is 1 and `dep_rs1` or `dep_rs2` equals that issue's destination tag. In every other case it is 0.
- R8: Operations issued in consecutive cycles each accumulate onto the result of the one before, with no stall and no lost update.
- R9: A software write with `sw_wr_sel` = 0 loads all 32 bits of `hi_o`. A write with `sw_wr_sel` = 1 loads `acc_lo_o`. The new value is visible in the next cycle.
- R10: A software write taken in the same cycle as an accumulator update is discarded, whichever register it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue a multiply-accumulate this cycle |
| iss_kind | input | 1 | 0 unsigned, 1 signed |
| iss_src_a | input | 32 | First source operand |
| iss_src_b | input | 32 | Second source operand |
| iss_dst | input | 5 | Destination register tag |
| dep_valid | input | 1 | Decode holds an instruction whose sources are given |
| dep_rs1 | input | 5 | First source tag of the decoded instruction |
| dep_rs2 | input | 5 | Second source tag of the decoded instruction |
| sw_wr_en | input | 1 | Software register write |
| sw_wr_sel | input | 1 | 0 high register, 1 low accumulator register |
| sw_wr_data | input | 32 | Software write data |
| hi_o | output | 32 | High register (accumulator bits [39:32] in [7:0]) |
| acc_lo_o | output | 32 | Low accumulator register |
| wb_valid | output | 1 | Writeback valid |
| wb_dst | output | 5 | Writeback destination tag |
| wb_data | output | 32 | Writeback data |
| stall | output | 1 | Hold the decoded instruction one cycle |

## Verification
The hardest state to reach from the ports is a software write that lands on the exact edge where an in-flight operation updates the accumulator. To get there, the bench issues an operation and then asserts the write one cycle later, once against each register. Wrap-around is the next hardest: the bench uses software writes to preload a full-scale accumulator with marker bits in the upper part of the high register, then adds a small product. That shows the carry out of bit 39 being dropped while bits [31:8] of the high register stay as they were.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic {
    MAC_UNSIGNED = 1'b0,
    MAC_SIGNED   = 1'b1
  } mac_kind_e;

  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } acc_sel_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OPND_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_kind,
  input  logic [OPND_W-1:0] in_a,
  input  logic [OPND_W-1:0] in_b,
  input  logic [TAG_W-1:0]  in_dst,
  output logic              s1_valid,
  output logic [ACC_W-1:0]  s1_prod,
  output logic [TAG_W-1:0]  s1_dst
);
  import mac_pkg::*;

  localparam int EXT_OP_W = OPND_W + 1;
  localparam int PROD_W   = 2 * EXT_OP_W;
  localparam int PAD_W    = ACC_W - PROD_W;

  logic                       sgn;
  logic signed [EXT_OP_W-1:0] ea;
  logic signed [EXT_OP_W-1:0] eb;
  logic signed [PROD_W-1:0]   p;
  logic [ACC_W-1:0]           p_ext;

  // One extra operand bit turns both kinds into a single signed multiply;
  // unsigned inputs get a zero there, so their product is never negative.
  always_comb begin
    sgn   = (in_kind == MAC_SIGNED);
    ea    = {sgn & in_a[OPND_W-1], in_a};
    eb    = {sgn & in_b[OPND_W-1], in_b};
    p     = ea * eb;
    p_ext = {{PAD_W{p[PROD_W-1]}}, p};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_prod  <= '0;
      s1_dst   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_prod <= p_ext;
        s1_dst  <= in_dst;
      end
    end
  end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [ACC_W-1:0]  s1_prod,
  input  logic [TAG_W-1:0]  s1_dst,
  input  logic              sw_wr_en,
  input  logic              sw_wr_sel,
  input  logic [DATA_W-1:0] sw_wr_data,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data
);
  import mac_pkg::*;

  localparam int HI_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] sum;

  // Reads the live registers: an update at the previous edge is already in
  // them, so back-to-back operations chain with no bypass path.
  always_comb sum = {hi_q[HI_W-1:0], lo_q} + s1_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      lo_q     <= '0;
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= s1_valid;
      if (s1_valid) begin
        lo_q             <= sum[DATA_W-1:0];
        hi_q[HI_W-1:0]   <= sum[ACC_W-1:DATA_W];
        wb_dst           <= s1_dst;
        wb_data          <= sum[DATA_W-1:0];
      end else if (sw_wr_en) begin
        if (sw_wr_sel == SEL_HI) hi_q <= sw_wr_data;
        else                     lo_q <= sw_wr_data;
      end
    end
  end

endmodule

// File: rtl/mac_hazard.sv
module mac_hazard #(
  parameter int TAG_W = 5
) (
  input  logic             s1_valid,
  input  logic [TAG_W-1:0] s1_dst,
  input  logic             dep_valid,
  input  logic [TAG_W-1:0] dep_rs1,
  input  logic [TAG_W-1:0] dep_rs2,
  output logic             stall
);
  logic hit1;
  logic hit2;

  always_comb begin
    hit1  = (dep_rs1 == s1_dst);
    hit2  = (dep_rs2 == s1_dst);
    stall = s1_valid & dep_valid & (hit1 | hit2);
  end

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int DATA_W = 32,
  parameter int OPND_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_kind,
  input  logic [DATA_W-1:0] iss_src_a,
  input  logic [DATA_W-1:0] iss_src_b,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              dep_valid,
  input  logic [TAG_W-1:0]  dep_rs1,
  input  logic [TAG_W-1:0]  dep_rs2,
  input  logic              sw_wr_en,
  input  logic              sw_wr_sel,
  input  logic [DATA_W-1:0] sw_wr_data,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] acc_lo_o,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output logic              stall
);

  logic              s1_valid;
  logic [ACC_W-1:0]  s1_prod;
  logic [TAG_W-1:0]  s1_dst;

  mac_mult #(.OPND_W(OPND_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) mult_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (iss_valid),
    .in_kind  (iss_kind),
    .in_a     (iss_src_a[OPND_W-1:0]),
    .in_b     (iss_src_b[OPND_W-1:0]),
    .in_dst   (iss_dst),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_dst   (s1_dst)
  );

  mac_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) accum_i (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_prod    (s1_prod),
    .s1_dst     (s1_dst),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_sel  (sw_wr_sel),
    .sw_wr_data (sw_wr_data),
    .hi_q       (hi_o),
    .lo_q       (acc_lo_o),
    .wb_valid   (wb_valid),
    .wb_dst     (wb_dst),
    .wb_data    (wb_data)
  );

  mac_hazard #(.TAG_W(TAG_W)) hazard_i (
    .s1_valid  (s1_valid),
    .s1_dst    (s1_dst),
    .dep_valid (dep_valid),
    .dep_rs1   (dep_rs1),
    .dep_rs2   (dep_rs2),
    .stall     (stall)
  );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  parameter int TAG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic              dep_valid,
  input logic              sw_wr_en,
  input logic              sw_wr_sel,
  input logic [DATA_W-1:0] hi_o,
  input logic [DATA_W-1:0] acc_lo_o,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data,
  input logic              stall
);
  localparam int HI_W = ACC_W - DATA_W;

  AST_WB_AFTER_TWO: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(iss_valid, 2)) else $error("wb without issue"); // R5

  AST_WB_MATCHES_ACC: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_data == acc_lo_o)) else $error("wb/acc mismatch"); // R5

  AST_HI_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    !$past(sw_wr_en) |-> $stable(hi_o[DATA_W-1:HI_W])) else $error("hi upper changed"); // R6

  AST_LO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!wb_valid && !$past(sw_wr_en)) |-> $stable(acc_lo_o)) else $error("acc changed idle"); // R4

  AST_STALL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    stall |-> ($past(iss_valid) && dep_valid)) else $error("stray stall"); // R7

  AST_COLLIDE_MAC_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(sw_wr_en && sw_wr_sel) && wb_valid) |-> (acc_lo_o == wb_data)) else $error("sw won"); // R10

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W), .TAG_W(TAG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .iss_valid (iss_valid),
  .dep_valid (dep_valid),
  .sw_wr_en  (sw_wr_en),
  .sw_wr_sel (sw_wr_sel),
  .hi_o      (hi_o),
  .acc_lo_o  (acc_lo_o),
  .wb_valid  (wb_valid),
  .wb_data   (wb_data),
  .stall     (stall)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic        iss_kind = 1'b0;
  logic [31:0] iss_src_a = '0;
  logic [31:0] iss_src_b = '0;
  logic [4:0]  iss_dst = '0;
  logic        dep_valid = 1'b0;
  logic [4:0]  dep_rs1 = '0;
  logic [4:0]  dep_rs2 = '0;
  logic        sw_wr_en = 1'b0;
  logic        sw_wr_sel = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] hi_o;
  logic [31:0] acc_lo_o;
  logic        wb_valid;
  logic [4:0]  wb_dst;
  logic [31:0] wb_data;
  logic        stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit dut_i (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_kind(iss_kind),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .dep_valid(dep_valid), .dep_rs1(dep_rs1), .dep_rs2(dep_rs2),
    .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
    .hi_o(hi_o), .acc_lo_o(acc_lo_o), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .wb_data(wb_data), .stall(stall)
  );

  typedef struct packed {
    logic [4:0]  dst;
    logic [31:0] lo;
    logic [31:0] hi;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          failures = 0;
  logic [39:0] m_acc = '0;
  logic [31:0] m_hi = '0;
  bit          finished = 0;

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model_prod(bit sgn, logic [31:0] a, logic [31:0] b);
    logic signed [31:0] sp;
    logic [31:0]        up;
    if (sgn) begin
      sp = $signed(a[15:0]) * $signed(b[15:0]);
      return {{8{sp[31]}}, sp};
    end
    up = a[15:0] * b[15:0];
    return {8'h00, up};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Driver: presents one issue, predicts its result and queues it.
  task automatic issue(bit sgn, logic [31:0] a, logic [31:0] b, logic [4:0] dst);
    exp_t e;
    iss_valid = 1'b1; iss_kind = sgn; iss_src_a = a; iss_src_b = b; iss_dst = dst;
    m_acc = m_acc + model_prod(sgn, a, b);
    m_hi  = {m_hi[31:8], m_acc[39:32]};
    e.dst = dst; e.lo = m_acc[31:0]; e.hi = m_hi;
    sb_q.push_back(e);
    step();
    iss_valid = 1'b0;
  endtask

  task automatic sw_write(bit sel, logic [31:0] d);
    sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = d;
    step();
    sw_wr_en = 1'b0;
    if (sel) m_acc[31:0] = d;
    else begin m_hi = d; m_acc[39:32] = d[7:0]; end
    if (sel) check32("R9 lo write", acc_lo_o, d);
    else     check32("R9 hi write", hi_o, d);
  endtask

  task automatic drain();
    repeat (3) step();
  endtask

  task automatic stall_chk(string req, bit exp);
    #1;
    check32(req, {31'b0, stall}, {31'b0, exp});
  endtask

  // Monitor: pops one expected item per writeback.
  always @(negedge clk) begin
    if (!rst && wb_valid) begin
      if (sb_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 unexpected writeback actual=%h expected=none", wb_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check32("R5 wb_data", wb_data, e.lo);
        check32("R5 wb_dst", {27'b0, wb_dst}, {27'b0, e.dst});
        check32("R4 acc_lo", acc_lo_o, e.lo);
        check32("R4/R6 hi", hi_o, e.hi);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1 hi reset", hi_o, 0);
    check32("R1 lo reset", acc_lo_o, 0);
    check32("R1 wb_valid reset", {31'b0, wb_valid}, 0);
    check32("R1 wb_data reset", wb_data, 0);
    rst = 1'b0;
    step();
    check32("R1 after reset", {31'b0, stall}, 0);

    // R2: upper operand bits ignored
    issue(0, 32'hABCD_0003, 32'h1234_0005, 5'd3);
    drain();
    check32("R2 unsigned low halves", acc_lo_o, 32'd15);

    // R3: signed
    issue(1, 32'h0000_FFFF, 32'hFFFF_0002, 5'd4);
    drain();
    check32("R3 signed -1*2", acc_lo_o, 32'd13);
    issue(1, 32'h0000_8000, 32'h0000_7FFF, 5'd5);
    drain();
    check32("R3 sign-extended top byte", {24'b0, hi_o[7:0]}, 32'hFF);
    // R2 large unsigned, carries into high byte
    issue(0, 32'h0000_FFFF, 32'h0000_FFFF, 5'd6);
    issue(0, 32'h0000_FFFF, 32'h0000_FFFF, 5'd6);
    drain();

    // R4 wrap and R6 upper high kept
    sw_write(1, 32'hFFFF_FFFF);
    sw_write(0, 32'hA5A5_A5FF);
    issue(0, 32'd1, 32'd2, 5'd7);
    drain();
    check32("R4 wrap modulo 2^40", acc_lo_o, 32'd1);
    check32("R6 hi upper kept", hi_o, 32'hA5A5_A500);

    // R8 back-to-back with unrelated dependent instruction
    issue(0, 32'd10, 32'd10, 5'd8);
    dep_valid = 1'b1; dep_rs1 = 5'd1; dep_rs2 = 5'd2;
    stall_chk("R8 no stall back-to-back", 0);
    issue(1, 32'h0000_FFFE, 32'd3, 5'd9);
    stall_chk("R8 no stall second", 0);
    issue(0, 32'd7, 32'd7, 5'd10);
    dep_valid = 1'b0;
    drain();

    // R7 stall cases
    issue(0, 32'd1, 32'd1, 5'd12);
    dep_valid = 1'b1; dep_rs1 = 5'd0; dep_rs2 = 5'd12;
    stall_chk("R7 stall rs2 match", 1);
    step();
    stall_chk("R7 stall one cycle only", 0);
    dep_valid = 1'b0;
    issue(0, 32'd1, 32'd1, 5'd13);
    dep_rs1 = 5'd13; dep_rs2 = 5'd0;
    stall_chk("R7 no stall when dep invalid", 0);
    dep_valid = 1'b1;
    stall_chk("R7 stall rs1 match", 1);
    dep_valid = 1'b0;
    drain();

    // R10 collisions
    issue(0, 32'd2, 32'd3, 5'd14);
    sw_wr_en = 1'b1; sw_wr_sel = 1'b1; sw_wr_data = 32'hDEAD_0000;
    step();
    sw_wr_en = 1'b0;
    check32("R10 lo write discarded", acc_lo_o, m_acc[31:0]);
    issue(0, 32'd2, 32'd3, 5'd15);
    sw_wr_en = 1'b1; sw_wr_sel = 1'b0; sw_wr_data = 32'h1234_5600;
    step();
    sw_wr_en = 1'b0;
    check32("R10 hi write discarded", hi_o, m_hi);
    drain();

    checks++;
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R5 missing writebacks actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule